// File: doc/BRIEF.md
# Programmable 3x3 Pixel Color Converter

This block converts a stream of three-component pixels, eight bits per component, between colour spaces. Each valid pixel passes through a three-register pipeline. In the first register its components are offset. In the second they are multiplied by a programmable 3x3 matrix. In the third the products are summed, rounded and clamped back to eight bits. There are three modes. Pass-through leaves pixels untouched and serves when the input and output colour spaces are the same. Luma/chroma-to-RGB adds three signed offsets to the input components before the multiply. RGB-to-luma/chroma adds the same offsets to the matrix result instead.

Software loads the nine coefficients, the three offsets and the mode through a write-only register port. These values sit in a programmed copy. They move into the active copy used by the datapath only on a cycle when no pixel is entering the block and none is waiting in the first pipeline register. A running stream therefore never mixes two configurations.

Top module: `csc_matrix_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_pix` is 0, every coefficient and offset is 0 and the mode is pass-through, so pixels sent before any configuration come out unchanged.
- R2: A pixel accepted on the clock edge where `in_valid` is 1 appears on the output two edges later. Every output sample is three cycles behind its input sample, and gaps in the input are kept.
- R3: Mode code 0 (control register at address 0, bits [1:0]) and code 3 both pass `pix_in` to `out_pix` unchanged.
- R4: In mode code 1 (luma/chroma to RGB), each 9-bit two's-complement offset is added to its input component before the multiply. Output row r is then the sum over c of coef[r][c] * (in[c] + ofs[c]).
- R5: In mode code 2 (RGB to luma/chroma), output row r is the sum over c of coef[r][c] * in[c], plus ofs[r] taken as a whole number.
- R6: Coefficients are 11-bit two's complement with 8 fraction bits, so 0x100 is 1.0. Addresses 1 to 4 each hold two row-major coefficients (index 2a-2 in bits [10:0], index 2a-1 in bits [26:16]). Address 5 holds coefficient 8 in bits [10:0] and offset 0 in bits [24:16]. Address 6 holds offset 1 in bits [8:0] and offset 2 in bits [24:16]. Component 0 is `pix_in[23:16]`, component 2 is `pix_in[7:0]`.
- R7: Before the 8 fraction bits are dropped, each result has half an output step (128) added to it, so an exact .5 rounds up.
- R8: Results below 0 come out as 0 and results above 255 come out as 255.
- R9: Configuration writes made while pixels stream back-to-back do not affect those pixels. They take effect for pixels sent after the pipeline has emptied and the input has been idle for a cycle.
- R10: While `out_valid` is 0, `out_pix` is 0.
- R11: A write to address 7 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| pix_in | input | 24 | Input pixel, component 0 in the top byte |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | Converted pixel, component 0 in the top byte |

## Verification
On every cycle, the bound checker checks four things. The output valid trails the input valid by exactly three samples. Pass-through pixels reappear unchanged. The active configuration holds still whenever a pixel is entering or sitting in the first stage. The output data is zero while not valid. Only the bench's scenarios can show the arithmetic itself: offset placement per mode, the coefficient packing, half-step rounding and saturation at both ends, each compared against an integer model. They also show that a configuration written during a stream reaches only the later pixels, and that an unused address leaves results unchanged.

// File: rtl/csc_pkg.sv
// Shared widths and types of the colour converter.
// Assumes three components per pixel and a row-major 3x3 coefficient set.
package csc_pkg;
    localparam int COMP_W = 8;
    localparam int NCH    = 3;
    localparam int COEF_W = 11;
    localparam int FRAC_W = 8;
    localparam int OFS_W  = 9;
    localparam int X_W    = COMP_W + 2;
    localparam int PROD_W = COEF_W + X_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int PIX_W  = NCH * COMP_W;
    localparam int NCOEF  = NCH * NCH;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'b00,
        MODE_YC2RGB = 2'b01,
        MODE_RGB2YC = 2'b10,
        MODE_PASS2  = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e                          mode;
        logic [NCOEF-1:0][COEF_W-1:0]   coef;
        logic [NCH-1:0][OFS_W-1:0]      ofs;
    } cfg_t;
endpackage

// File: rtl/csc_cfg_regs.sv
// Configuration store: a programmed copy written by software and an
// active copy used by the datapath. The active copy only refreshes while
// the pipeline front is idle. Assumes DATA_W is at least 27.
module csc_cfg_regs
    import csc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pipe_busy,
    output cfg_t              act_cfg
);
    localparam int HI_LSB = 16;

    cfg_t prog;

    wire unused_wbits = &{1'b0, cfg_wdata[DATA_W-1:HI_LSB+COEF_W],
                          cfg_wdata[HI_LSB-1:COEF_W]};

    // Decode software writes into the programmed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_W'(0): prog.mode <= mode_e'(cfg_wdata[1:0]);
                ADDR_W'(1): begin
                    prog.coef[0] <= cfg_wdata[COEF_W-1:0];
                    prog.coef[1] <= cfg_wdata[HI_LSB +: COEF_W];
                end
                ADDR_W'(2): begin
                    prog.coef[2] <= cfg_wdata[COEF_W-1:0];
                    prog.coef[3] <= cfg_wdata[HI_LSB +: COEF_W];
                end
                ADDR_W'(3): begin
                    prog.coef[4] <= cfg_wdata[COEF_W-1:0];
                    prog.coef[5] <= cfg_wdata[HI_LSB +: COEF_W];
                end
                ADDR_W'(4): begin
                    prog.coef[6] <= cfg_wdata[COEF_W-1:0];
                    prog.coef[7] <= cfg_wdata[HI_LSB +: COEF_W];
                end
                ADDR_W'(5): begin
                    prog.coef[8] <= cfg_wdata[COEF_W-1:0];
                    prog.ofs[0]  <= cfg_wdata[HI_LSB +: OFS_W];
                end
                ADDR_W'(6): begin
                    prog.ofs[1]  <= cfg_wdata[OFS_W-1:0];
                    prog.ofs[2]  <= cfg_wdata[HI_LSB +: OFS_W];
                end
                default: ;
            endcase
        end
    end

    // Copy programmed values into the active set when nothing is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_cfg <= '0;
        else if (!pipe_busy)
            act_cfg <= prog;
    end
endmodule

// File: rtl/csc_pre_stage.sv
// Stage 1: splits the pixel into components and applies the offsets.
// In luma/chroma-to-RGB mode offsets join the inputs. In RGB-to-luma/chroma
// mode they are carried on to be added after the matrix.
module csc_pre_stage
    import csc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [PIX_W-1:0]            pix_in,
    input  cfg_t                        act_cfg,
    output logic                        s1_valid,
    output mode_e                       s1_mode,
    output logic [PIX_W-1:0]            s1_raw,
    output logic [NCH-1:0][X_W-1:0]     s1_x,
    output logic [NCH-1:0][OFS_W-1:0]   s1_post
);
    // Register valid, mode and the untouched pixel for the pass-through path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= MODE_PASS;
            s1_raw   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_mode  <= act_cfg.mode;
            s1_raw   <= pix_in;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [COMP_W-1:0] comp;
        logic [OFS_W-1:0]  ofs;
        logic [X_W-1:0]    x_n;
        logic [OFS_W-1:0]  post_n;

        assign comp = pix_in[(NCH-1-ch)*COMP_W +: COMP_W];
        assign ofs  = act_cfg.ofs[ch];

        // Choose where this component's offset goes for the current mode.
        always_comb begin
            x_n    = {2'b00, comp};
            post_n = '0;
            if (act_cfg.mode == MODE_YC2RGB)
                x_n = {2'b00, comp} + {{(X_W-OFS_W){ofs[OFS_W-1]}}, ofs};
            else if (act_cfg.mode == MODE_RGB2YC)
                post_n = ofs;
        end

        // Hold the offset component and its deferred offset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_x[ch]    <= '0;
                s1_post[ch] <= '0;
            end else begin
                s1_x[ch]    <= x_n;
                s1_post[ch] <= post_n;
            end
        end
    end
endmodule

// File: rtl/csc_mult_stage.sv
// Stage 2: forms all nine signed products of offset components and
// coefficients. Assumes the active coefficients are stable while s1_valid.
module csc_mult_stage
    import csc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s1_valid,
    input  mode_e                         s1_mode,
    input  logic [PIX_W-1:0]              s1_raw,
    input  logic [NCH-1:0][X_W-1:0]       s1_x,
    input  logic [NCH-1:0][OFS_W-1:0]     s1_post,
    input  cfg_t                          act_cfg,
    output logic                          s2_valid,
    output mode_e                         s2_mode,
    output logic [PIX_W-1:0]              s2_raw,
    output logic [NCH-1:0][OFS_W-1:0]     s2_post,
    output logic [NCOEF-1:0][PROD_W-1:0]  s2_prod
);
    // Carry control, the raw pixel and the deferred offsets along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_mode  <= MODE_PASS;
            s2_raw   <= '0;
            s2_post  <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_mode  <= s1_mode;
            s2_raw   <= s1_raw;
            s2_post  <= s1_post;
        end
    end

    for (genvar r = 0; r < NCH; r++) begin : g_row
        for (genvar c = 0; c < NCH; c++) begin : g_col
            logic signed [PROD_W-1:0] prod_n;

            assign prod_n = $signed(s1_x[c]) * $signed(act_cfg.coef[r*NCH+c]);

            // Register one matrix product.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    s2_prod[r*NCH+c] <= '0;
                else
                    s2_prod[r*NCH+c] <= prod_n;
            end
        end
    end
endmodule

// File: rtl/csc_sum_stage.sv
// Stage 3: sums each matrix row, adds the deferred offset and the rounding
// half step, drops the fraction bits and saturates to the component range.
// Selects the raw pixel in pass-through modes and zeroes idle output.
module csc_sum_stage
    import csc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s2_valid,
    input  mode_e                         s2_mode,
    input  logic [PIX_W-1:0]              s2_raw,
    input  logic [NCH-1:0][OFS_W-1:0]     s2_post,
    input  logic [NCOEF-1:0][PROD_W-1:0]  s2_prod,
    output logic                          out_valid,
    output logic [PIX_W-1:0]              out_pix
);
    localparam int MAXV = (1 << COMP_W) - 1;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W-1));
    localparam logic signed [ACC_W-1:0] TOP = ACC_W'(MAXV);

    logic [PIX_W-1:0] conv;
    logic             pass;

    assign pass = (s2_mode == MODE_PASS) || (s2_mode == MODE_PASS2);

    for (genvar r = 0; r < NCH; r++) begin : g_row
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] shr;
        logic [COMP_W-1:0]       sat;

        // Accumulate one row with offset and rounding, then saturate.
        always_comb begin
            acc = (ACC_W'($signed(s2_post[r])) <<< FRAC_W) + RND;
            for (int c = 0; c < NCH; c++)
                acc = acc + ACC_W'($signed(s2_prod[r*NCH+c]));
            shr = acc >>> FRAC_W;
            if (shr[ACC_W-1])
                sat = '0;
            else if (shr > TOP)
                sat = '1;
            else
                sat = shr[COMP_W-1:0];
        end

        assign conv[(NCH-1-r)*COMP_W +: COMP_W] = sat;
    end

    // Register the output pixel, zero when no pixel is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2_valid;
            out_pix   <= !s2_valid ? '0 : (pass ? s2_raw : conv);
        end
    end
endmodule

// File: rtl/csc_matrix_top.sv
// Programmable 3x3 colour converter with three pipeline registers.
// Assumes a single clock and synchronous active-low reset; configuration
// writes are accepted any cycle and applied only between pixel bursts.
module csc_matrix_top
    import csc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    cfg_t                          act_cfg;
    logic                          s1_valid;
    mode_e                         s1_mode;
    logic [PIX_W-1:0]              s1_raw;
    logic [NCH-1:0][X_W-1:0]       s1_x;
    logic [NCH-1:0][OFS_W-1:0]     s1_post;
    logic                          s2_valid;
    mode_e                         s2_mode;
    logic [PIX_W-1:0]              s2_raw;
    logic [NCH-1:0][OFS_W-1:0]     s2_post;
    logic [NCOEF-1:0][PROD_W-1:0]  s2_prod;
    logic                          pipe_busy;

    // The front of the pipe reads the active configuration.
    assign pipe_busy = in_valid | s1_valid;

    csc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pipe_busy(pipe_busy), .act_cfg(act_cfg)
    );

    csc_pre_stage pre_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_in(pix_in),
        .act_cfg(act_cfg), .s1_valid(s1_valid), .s1_mode(s1_mode),
        .s1_raw(s1_raw), .s1_x(s1_x), .s1_post(s1_post)
    );

    csc_mult_stage mult_i (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_mode(s1_mode),
        .s1_raw(s1_raw), .s1_x(s1_x), .s1_post(s1_post), .act_cfg(act_cfg),
        .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_raw(s2_raw),
        .s2_post(s2_post), .s2_prod(s2_prod)
    );

    csc_sum_stage sum_i (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_mode(s2_mode),
        .s2_raw(s2_raw), .s2_post(s2_post), .s2_prod(s2_prod),
        .out_valid(out_valid), .out_pix(out_pix)
    );
endmodule

// File: rtl/csc_matrix_chk.sv
// Assertion checker for csc_matrix_top, attached by bind below.
// Assumes the clock runs during reset so the reset edge is seen.
module csc_matrix_chk
    import csc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] pix_in,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic             s1_valid,
    input cfg_t             act_cfg
);
    logic [1:0] since_rst;
    logic       prev_rst_low = 1'b0;

    // Count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1: an edge with reset low leaves the output empty.
    always_ff @(posedge clk) begin
        prev_rst_low <= !rst_n;
        if (prev_rst_low)
            a_r1_reset_clears: assert (!out_valid && out_pix == '0);
    end

    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r3_pass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3) &&
         ($past(act_cfg.mode, 3) == MODE_PASS || $past(act_cfg.mode, 3) == MODE_PASS2))
        |-> (out_pix == $past(pix_in, 3)));

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid || s1_valid) |=> $stable(act_cfg));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0));
endmodule

bind csc_matrix_top csc_matrix_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_in(pix_in),
    .out_valid(out_valid), .out_pix(out_pix), .s1_valid(s1_valid),
    .act_cfg(act_cfg)
);

// File: tb/csc_matrix_top_tb_top.sv
// Directed bench for csc_matrix_top with an integer reference model.
module csc_matrix_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [23:0] pix_in = '0;
    logic        out_valid;
    logic [23:0] out_pix;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_mode;
    int m_coef[9];
    int m_ofs[3];
    typedef int arr9_t[9];
    typedef int arr3_t[3];

    logic [23:0] stim_q[$];
    logic [23:0] exp_q[$];
    logic [23:0] got_q[$];

    // Coefficient sets (11-bit codes, row-major) and offsets (9-bit codes).
    localparam arr9_t YC601 = '{12'h12a, 12'h000, 12'h199, 12'h12a, 12'h79c,
                                12'h730, 12'h12a, 12'h204, 12'h000};
    localparam arr3_t YC601_O = '{12'h1f0, 12'h180, 12'h180};
    localparam arr9_t RGB601 = '{12'h041, 12'h081, 12'h019, 12'h7db, 12'h7b6,
                                 12'h070, 12'h070, 12'h7a2, 12'h7ee};
    localparam arr3_t RGB601_O = '{12'h010, 12'h080, 12'h080};

    csc_matrix_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .pix_in(pix_in),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    always #4 clk = ~clk;

    function automatic int sx(int v, int w);
        return (v >= (1 << (w-1))) ? v - (1 << w) : v;
    endfunction

    // Reference model built from R3..R8.
    function automatic logic [23:0] model(logic [23:0] p);
        logic [23:0] res;
        int comp[3];
        for (int i = 0; i < 3; i++) comp[i] = int'(p[23-8*i -: 8]);
        if (m_mode == 0 || m_mode == 3) return p;
        for (int r = 0; r < 3; r++) begin
            int acc = 0;
            for (int c = 0; c < 3; c++) begin
                int x = comp[c] + ((m_mode == 1) ? sx(m_ofs[c], 9) : 0);
                acc += sx(m_coef[r*3+c], 11) * x;
            end
            if (m_mode == 2) acc += sx(m_ofs[r], 9) * 256;
            acc = (acc + 128) >>> 8;
            if (acc < 0) acc = 0;
            if (acc > 255) acc = 255;
            res[23-8*r -: 8] = 8'(acc);
        end
        return res;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(int addr, logic [31:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic write_regs(int mode, arr9_t c, arr3_t o);
        cfg_write(1, 32'((c[1] << 16) | c[0]));
        cfg_write(2, 32'((c[3] << 16) | c[2]));
        cfg_write(3, 32'((c[5] << 16) | c[4]));
        cfg_write(4, 32'((c[7] << 16) | c[6]));
        cfg_write(5, 32'((o[0] << 16) | c[8]));
        cfg_write(6, 32'((o[2] << 16) | o[1]));
        cfg_write(0, 32'(mode));
    endtask

    task automatic set_model(int mode, arr9_t c, arr3_t o);
        m_mode = mode; m_coef = c; m_ofs = o;
    endtask

    task automatic load_cfg(int mode, arr9_t c, arr3_t o);
        write_regs(mode, c, o);
        set_model(mode, c, o);
        repeat (3) @(posedge clk);
    endtask

    task automatic push_pix(logic [23:0] p);
        stim_q.push_back(p);
        exp_q.push_back(model(p));
    endtask

    // Drive queued pixels back to back, drain, compare against the model.
    task automatic play(string tag);
        got_q.delete();
        foreach (stim_q[i]) begin
            @(posedge clk); #1;
            in_valid = 1'b1; pix_in = stim_q[i];
        end
        @(posedge clk); #1;
        in_valid = 1'b0; pix_in = '0;
        repeat (6) @(posedge clk);
        check({tag, " count"}, got_q.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < got_q.size()) check(tag, got_q[i], exp_q[i]);
        stim_q.delete(); exp_q.delete();
    endtask

    // Monitor: collect outputs and check R2 latency against input history.
    logic [2:0] vh;
    int seen;
    always @(negedge clk) begin
        if (!rst_n) begin
            vh = '0; seen = 0;
        end else begin
            if (out_valid) got_q.push_back(out_pix);
            if (seen >= 3 && (out_valid || vh[2]))
                check("R2 latency", 32'(out_valid), 32'(vh[2]));
            vh = {vh[1:0], in_valid};
            seen++;
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", 32'(out_valid), 0);
        check("R1 out_pix in reset", 32'(out_pix), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        set_model(0, '{0,0,0,0,0,0,0,0,0}, '{0,0,0});
        push_pix(24'h12_34_56); push_pix(24'hff_00_80);
        play("R1 default pass");
    endtask

    task automatic t_bypass();
        load_cfg(0, YC601, YC601_O);
        push_pix(24'h00_00_00); push_pix(24'h10_80_80); push_pix(24'hab_cd_ef);
        play("R3 mode0");
        load_cfg(3, RGB601, RGB601_O);
        push_pix(24'h01_02_03); push_pix(24'hff_ff_ff);
        play("R3 mode3");
    endtask

    task automatic t_yc2rgb();
        load_cfg(1, YC601, YC601_O);
        push_pix(24'h10_80_80); push_pix(24'heb_80_80); push_pix(24'h51_5a_f0);
        push_pix(24'h91_36_22); push_pix(24'h29_f0_6e);
        play("R4 R6 luma/chroma to rgb");
        load_cfg(1, YC601, YC601_O);
        push_pix(24'h10_80_80);
        play("R4 black");
        check("R4 black literal", 32'(model(24'h10_80_80)), 32'h00_00_00);
    endtask

    task automatic t_rgb2yc();
        load_cfg(2, RGB601, RGB601_O);
        push_pix(24'h00_00_00); push_pix(24'hff_ff_ff); push_pix(24'hff_00_00);
        push_pix(24'h00_ff_00); push_pix(24'h20_40_c0);
        play("R5 rgb to luma/chroma");
        check("R5 black literal", 32'(model(24'h00_00_00)), 32'h10_80_80);
    endtask

    task automatic t_round();
        load_cfg(1, '{12'h080,0,0,0,0,0,0,0,0}, '{0,0,0});
        push_pix(24'h01_00_00); push_pix(24'h03_00_00);
        play("R7 half-step rounding");
        check("R7 1*0.5 rounds to 1", 32'(model(24'h01_00_00)), 32'h01_00_00);
        check("R7 3*0.5 rounds to 2", 32'(model(24'h03_00_00)), 32'h02_00_00);
    endtask

    task automatic t_clamp();
        load_cfg(1, YC601, YC601_O);
        push_pix(24'hff_00_ff); push_pix(24'h00_00_00); push_pix(24'hff_ff_00);
        play("R8 saturation");
        check("R8 high clamp literal", 32'(model(24'hff_00_ff) >> 16), 32'hff);
        check("R8 low clamp literal", 32'(model(24'h00_00_00) >> 16), 32'h00);
    endtask

    task automatic t_frozen();
        load_cfg(1, YC601, YC601_O);
        for (int i = 0; i < 10; i++) push_pix(24'(32'h203040 + i * 32'h111111));
        fork
            play("R9 stream keeps old config");
            begin
                repeat (3) @(posedge clk);
                write_regs(2, RGB601, RGB601_O);
            end
        join
        set_model(2, RGB601, RGB601_O);
        repeat (3) @(posedge clk);
        push_pix(24'h20_40_c0); push_pix(24'hff_ff_ff);
        play("R9 next burst uses new config");
    endtask

    task automatic t_unused_addr();
        cfg_write(7, 32'hffff_ffff);
        repeat (3) @(posedge clk);
        push_pix(24'h20_40_c0); push_pix(24'h80_80_80);
        play("R11 address 7 ignored");
    endtask

    task automatic t_idle_zero();
        load_cfg(0, YC601, YC601_O);
        push_pix(24'hff_ff_ff);
        play("R10 stream");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 idle valid", 32'(out_valid), 0);
            check("R10 idle data zero", 32'(out_pix), 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_yc2rgb();
        t_rgb2yc();
        t_round();
        t_clamp();
        t_frozen();
        t_unused_addr();
        t_idle_zero();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule